// File: doc/BRIEF.md
# EDO Page-Mode DRAM Access Controller

This block sits between a simple request port and one 2M x 8 extended-data-out DRAM. Each request carries a 21-bit word address, a read/write flag and a write byte. The controller splits the address into a row half and a column half and drives both halves on one shared set of address pins. It sequences the row strobe, column strobe, write enable and output enable to match the DRAM's timing, counting each limit in clock cycles that are derived from nanosecond parameters.

A row stays open after an access. A following request to the same row is served with a column cycle only, so the row strobe stays low between the two. A request to a different row, an open page that reaches its maximum lifetime, or a refresh grant from the outside causes a row precharge. Writes are always early writes, so the DRAM never drives the data lines while the controller does. Read data is captured on the edge where the column strobe rises. The DRAM's extended output hold keeps that data valid across the edge. A one-cycle strobe then presents the byte.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held and after it is released, all four DRAM strobes are high (inactive), `dram_dq_oe` and `rd_valid` are 0, and with `refresh_gnt` low both `parked` and `req_ready` are 1.
- R2: The row is `req_addr[20:10]`. It is on `dram_addr` when the row strobe falls and stays there for at least 3 cycles (10 ns). The column is `req_addr[9:0]`. It is on `dram_addr[9:0]` before the column strobe falls and stays unchanged while that strobe is low.
- R3: A read returns the addressed byte on `rd_data`, with `rd_valid` high for one cycle. Data is sampled only once all three access times have passed: the column strobe has been low for at least 4 cycles (15 ns), the column address has been stable for at least 8 cycles (30 ns), and the row strobe has been low for at least 15 cycles (60 ns).
- R4: A write drives `dram_we_n` low, and drives data with `dram_dq_oe` = 1, at least one cycle before the column strobe falls. It keeps `dram_we_n` and the data unchanged while that strobe is low. `dram_oe_n` stays high whenever the controller drives data.
- R5: Successive requests to the same row, arriving while the page is open, are served without raising the row strobe.
- R6: Every row strobe fall is preceded by at least 10 cycles (40 ns) with the row strobe high. Once it has risen, it stays high on the next cycle.
- R7: The row strobe never stays low for more than `T_RASP_NS / CLK_NS` cycles. An open page left idle, or a stream of requests to one row, is closed before that limit.
- R8: While `refresh_gnt` is 1, `req_ready` is 0. Any open page is closed, and the controller then parks with the row strobe high and `parked` = 1.
- R9: The column strobe is low only while the row strobe is low. Each column-low phase lasts at least 3 cycles. Between two column-low phases within one row, the column strobe is high for at least 3 cycles.
- R10: Each row-strobe low phase lasts at least 15 cycles (60 ns).
- R11: A request is taken only in a cycle with `req_valid` and `req_ready` both 1. Each accepted read produces exactly one `rd_valid` pulse, and these pulses come in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_gnt | input | 1 | External refresh owns the DRAM; close the page and park |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address, row in the upper 11 bits |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 8 | Read byte |
| parked | output | 1 | Idle with the row strobe high and precharged |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Write data to the DRAM |
| dram_dq_oe | output | 1 | Controller drives the data lines |
| dram_dq_in | input | 8 | Data from the DRAM |

## Verification
The hardest case to reach from the ports is a page that is closed by its lifetime limit while same-row requests keep arriving. At the default limit this takes a long, steady stream of page hits. The bench lowers the lifetime parameter to 240 ns and streams ten same-row reads. It also leaves an open page idle. In both cases it checks that the row strobe rises and that later accesses reopen the row. The DRAM model in the bench returns a marker byte until all three access times have passed, so an early sample shows up as wrong read data.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROWSET,
    ST_RCD,
    ST_COLSET,
    ST_CASLO,
    ST_CASHI,
    ST_OPEN,
    ST_PRE
  } edo_state_e;

  // Whole clock cycles needed to cover a time in ns
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_step_timer.sv
module edo_step_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] elapsed
);
  logic [W-1:0] cnt;

  // Counts edges spent in the current state, saturating at half range
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (restart)    cnt <= '0;
    else if (!cnt[W-1])  cnt <= cnt + 1'b1;
  end

  assign elapsed = cnt + 1'b1;
endmodule

// File: rtl/edo_page_tracker.sv
module edo_page_tracker #(
  parameter int ROW_W    = 11,
  parameter int AGE_W    = 16,
  parameter int PAGE_MAX = 25000,
  parameter int HIT_SPAN = 12,
  parameter int RAS_MIN  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             load,
  input  logic [ROW_W-1:0] load_row,
  input  logic [ROW_W-1:0] req_row,
  output logic             row_hit,
  output logic             hit_window,
  output logic             ras_min_met,
  output logic [AGE_W-1:0] ras_el
);
  localparam logic [AGE_W-1:0] PAGE_L = AGE_W'(PAGE_MAX);
  localparam logic [AGE_W-1:0] SPAN_L = AGE_W'(HIT_SPAN);
  localparam logic [AGE_W-1:0] MIN_L  = AGE_W'(RAS_MIN);

  logic [ROW_W-1:0] open_row;
  logic [AGE_W-1:0] ras_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_row <= '0;
      ras_age  <= '0;
    end else begin
      if (load) open_row <= load_row;
      if (ras_n)                ras_age <= '0;
      else if (ras_age != '1)   ras_age <= ras_age + 1'b1;
    end
  end

  assign ras_el      = ras_age + 1'b1;
  assign row_hit     = (open_row == req_row);
  assign hit_window  = (ras_el + SPAN_L) <= PAGE_L;
  assign ras_min_met = ras_el >= MIN_L;

  // R7
  page_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> ras_age < PAGE_L);

  // R10
  ras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> ras_age >= MIN_L);
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W      = 11,
  parameter int COL_W      = 10,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 4,
  parameter int T_RP_NS    = 40,
  parameter int T_RAH_NS   = 10,
  parameter int T_CAS_NS   = 10,
  parameter int T_CP_NS    = 10,
  parameter int T_CAC_NS   = 15,
  parameter int T_AA_NS    = 30,
  parameter int T_RAC_NS   = 60,
  parameter int T_DH_NS    = 10,
  parameter int T_RAS_NS   = 60,
  parameter int T_RASP_NS  = 100000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   refresh_gnt,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   parked,
  output logic [ROW_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  localparam int RP_C   = ns_to_cyc(T_RP_NS, CLK_NS);
  localparam int RAH_C  = ns_to_cyc(T_RAH_NS, CLK_NS);
  localparam int CP_C   = ns_to_cyc(T_CP_NS, CLK_NS);
  localparam int RAC_C  = ns_to_cyc(T_RAC_NS, CLK_NS);
  localparam int RASM_C = ns_to_cyc(T_RAS_NS, CLK_NS);
  // Column cycle lengths; the column address leads the strobe by one cycle
  localparam int RD_LO  = imax(imax(ns_to_cyc(T_CAC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS) - 1),
                               ns_to_cyc(T_CAS_NS, CLK_NS));
  localparam int WR_LO  = imax(ns_to_cyc(T_CAS_NS, CLK_NS), ns_to_cyc(T_DH_NS, CLK_NS));
  localparam int HIT_SPAN = 1 + RD_LO + CP_C + 1;
  localparam int PAGE_MAX = T_RASP_NS / CLK_NS;
  localparam int TW     = $clog2(imax(imax(RP_C, RD_LO), imax(RAH_C, imax(CP_C, WR_LO))) + 1) + 1;
  localparam int AGE_W  = $clog2(PAGE_MAX + HIT_SPAN + RAC_C + 2) + 1;

  localparam logic [TW-1:0]    RP_T  = TW'(RP_C);
  localparam logic [TW-1:0]    RAH_T = TW'(RAH_C);
  localparam logic [TW-1:0]    CP_T  = TW'(CP_C);
  localparam logic [TW-1:0]    RDL_T = TW'(RD_LO);
  localparam logic [TW-1:0]    WRL_T = TW'(WR_LO);
  localparam logic [AGE_W-1:0] RAC_A = AGE_W'(RAC_C);

  function automatic logic [ROW_W-1:0] row_of(input logic [ROW_W+COL_W-1:0] a);
    return a[ROW_W+COL_W-1:COL_W];
  endfunction

  function automatic logic [ROW_W-1:0] col_pins(input logic [COL_W-1:0] c);
    return ROW_W'(c);
  endfunction

  edo_state_e        state, nxt;
  logic [TW-1:0]     st_el;
  logic [AGE_W-1:0]  ras_el;
  logic              row_hit, hit_window, ras_min_met;
  logic              accept_idle, accept_hit, take, close_now, rd_fire, rd_ok, wr_ok;
  logic              cur_write, wr_next, in_col;
  logic [COL_W-1:0]  cur_col;
  logic [DATA_W-1:0] cur_wdata, wd_next;

  edo_step_timer #(.W(TW)) step_i (
    .clk(clk), .rst_n(rst_n), .restart(nxt != state), .elapsed(st_el));

  edo_page_tracker #(
    .ROW_W(ROW_W), .AGE_W(AGE_W), .PAGE_MAX(PAGE_MAX),
    .HIT_SPAN(HIT_SPAN), .RAS_MIN(RASM_C)
  ) page_i (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n),
    .load(take && state == ST_IDLE), .load_row(row_of(req_addr)),
    .req_row(row_of(req_addr)), .row_hit(row_hit), .hit_window(hit_window),
    .ras_min_met(ras_min_met), .ras_el(ras_el));

  // Named internal events
  assign accept_idle = (state == ST_IDLE) && !refresh_gnt;
  assign accept_hit  = (state == ST_OPEN) && !refresh_gnt && row_hit && hit_window;
  assign req_ready   = accept_idle || accept_hit;
  assign take        = req_valid && req_ready;
  assign close_now   = (state == ST_OPEN) && !take && ras_min_met &&
                       (refresh_gnt || !hit_window || (req_valid && !row_hit));
  assign rd_ok       = (st_el >= RDL_T) && (ras_el >= RAC_A);
  assign wr_ok       = st_el >= WRL_T;
  assign rd_fire     = (state == ST_CASLO) && !cur_write && rd_ok;
  assign wr_next     = take ? req_write : cur_write;
  assign wd_next     = take ? req_wdata : cur_wdata;
  assign in_col      = (nxt == ST_COLSET) || (nxt == ST_CASLO);
  assign parked      = (state == ST_IDLE);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (take) nxt = ST_ROWSET;
      ST_ROWSET: nxt = ST_RCD;
      ST_RCD:    if (st_el >= RAH_T) nxt = ST_COLSET;
      ST_COLSET: nxt = ST_CASLO;
      ST_CASLO:  if (cur_write ? wr_ok : rd_ok) nxt = ST_CASHI;
      ST_CASHI:  if (st_el >= CP_T) nxt = ST_OPEN;
      ST_OPEN:   if (take) nxt = ST_COLSET;
                 else if (close_now) nxt = ST_PRE;
      ST_PRE:    if (st_el >= RP_T) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  // All DRAM pins are registered from the next state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      cur_write   <= 1'b0;
      cur_col     <= '0;
      cur_wdata   <= '0;
    end else begin
      state <= nxt;
      if (take) begin
        cur_write <= req_write;
        cur_col   <= req_addr[COL_W-1:0];
        cur_wdata <= req_wdata;
      end
      dram_ras_n <= (nxt == ST_IDLE) || (nxt == ST_ROWSET) || (nxt == ST_PRE);
      dram_cas_n <= (nxt != ST_CASLO);
      dram_we_n  <= !(in_col && wr_next);
      dram_dq_oe <= in_col && wr_next;
      if (in_col && wr_next) dram_dq_out <= wd_next;
      dram_oe_n  <= !((nxt == ST_CASLO) && !wr_next);
      if (take && state == ST_IDLE)
        dram_addr <= row_of(req_addr);
      else if (nxt == ST_COLSET)
        dram_addr <= take ? col_pins(req_addr[COL_W-1:0]) : col_pins(cur_col);
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= dram_dq_in;
    end
  end

  // R9
  cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  // R4
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> dram_oe_n);

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && $past(!dram_cas_n)) |-> ($stable(dram_we_n) && $stable(dram_dq_out)));

  // R2
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));

  // R6
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |=> dram_ras_n);

  // R11
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R8
  gnt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_gnt |-> !req_ready);
endmodule

// File: tb/edo_dram_ctrl_tb_top.sv
module edo_dram_ctrl_tb_top;
  localparam int CK     = 4;
  localparam int B_RP   = (40 + CK - 1) / CK;
  localparam int B_RAH  = (10 + CK - 1) / CK;
  localparam int B_CLO  = (10 + CK - 1) / CK;
  localparam int B_CP   = (10 + CK - 1) / CK;
  localparam int B_CAC  = (15 + CK - 1) / CK;
  localparam int B_AA   = (30 + CK - 1) / CK;
  localparam int B_RAC  = (60 + CK - 1) / CK;
  localparam int B_RMIN = (60 + CK - 1) / CK;
  localparam int RASP   = 240;
  localparam int B_PAGE = RASP / CK;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refresh_gnt = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rd_valid, parked;
  logic [7:0] rd_data;
  logic [10:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [7:0] dram_dq_out;
  logic [7:0] dram_dq_in = 8'hEE;

  always #2 clk = ~clk;

  edo_dram_ctrl #(.T_RASP_NS(RASP)) dut_i (
    .clk(clk), .rst_n(rst_n), .refresh_gnt(refresh_gnt),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .parked(parked), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in));

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    int t;
    t = a ^ (a >> 8) ^ (a >> 16) ^ 32'h5A;
    return t[7:0];
  endfunction

  // Bench-side view of memory contents and pending reads
  logic [7:0] shadow [int];
  logic [7:0] expq [$];

  // DRAM behavioural model, evaluated on the falling edge
  logic [7:0] mem [int];
  int ras_lo_n = 0, ras_hi_n = 100, cas_lo_n = 0, cas_hi_n = 100, addr_age = 0;
  int ras_falls = 0;
  int row_lat = 0;
  bit first_col = 1;
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
  logic [10:0] prev_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ras && !dram_ras_n) begin
        check(ras_hi_n >= B_RP, "R6 row precharge cycles", ras_hi_n, B_RP);
        row_lat = int'(dram_addr);
        ras_falls++;
        first_col = 1;
      end
      if (!prev_ras && dram_ras_n) begin
        check(ras_lo_n >= B_RMIN, "R10 row low cycles", ras_lo_n, B_RMIN);
        check(ras_lo_n <= B_PAGE, "R7 row low limit", ras_lo_n, B_PAGE);
      end
      if (!dram_ras_n && !prev_ras && dram_addr != prev_addr && first_col)
        check(ras_lo_n >= B_RAH, "R2 row hold cycles", ras_lo_n, B_RAH);
      if (prev_cas && !dram_cas_n) begin
        check(!dram_ras_n, "R9 column strobe inside row", dram_ras_n, 0);
        if (!first_col)
          check(cas_hi_n >= B_CP, "R9 column precharge cycles", cas_hi_n, B_CP);
        first_col = 0;
        if (!dram_we_n) begin
          check(!prev_we && dram_dq_oe && dram_oe_n, "R4 early write set-up",
                {prev_we, dram_dq_oe, dram_oe_n}, 3'b011);
          mem[row_lat * 1024 + int'(dram_addr[9:0])] = dram_dq_out;
        end
      end
      if (!prev_cas && dram_cas_n)
        check(cas_lo_n >= B_CLO, "R9 column low cycles", cas_lo_n, B_CLO);
      if (rd_valid) begin
        if (expq.size() == 0) check(0, "R11 unexpected read strobe", 1, 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          check(rd_data == e, "R3 read data", rd_data, e);
        end
      end
    end
    if (!dram_ras_n) begin ras_lo_n++; ras_hi_n = 0; end
    else begin ras_hi_n++; ras_lo_n = 0; end
    if (!dram_cas_n) begin cas_lo_n++; cas_hi_n = 0; end
    else begin cas_hi_n++; cas_lo_n = 0; end
    if (dram_addr == prev_addr) addr_age++;
    else addr_age = 1;
    if (!dram_ras_n && !dram_cas_n && dram_we_n && !dram_oe_n) begin
      int a;
      a = row_lat * 1024 + int'(dram_addr[9:0]);
      if (cas_lo_n >= B_CAC && addr_age >= B_AA && ras_lo_n >= B_RAC)
        dram_dq_in = mem.exists(a) ? mem[a] : pat(a);
      else
        dram_dq_in = 8'hEE;
    end
    prev_ras  = dram_ras_n;
    prev_cas  = dram_cas_n;
    prev_we   = dram_we_n;
    prev_addr = dram_addr;
  end

  task automatic issue(input bit w, input int a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a[20:0]; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (w) shadow[a] = d;
    else expq.push_back(shadow.exists(a) ? shadow[a] : pat(a));
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in reset",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
    check(!dram_dq_oe && !rd_valid, "R1 outputs in reset", {dram_dq_oe, rd_valid}, 0);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    check(parked && req_ready && dram_ras_n, "R1 idle after reset",
          {parked, req_ready, dram_ras_n}, 3'b111);

    // R5: two writes to one row share one row opening
    f0 = ras_falls;
    issue(1, (5 << 10) | 1, 8'h11);
    issue(1, (5 << 10) | 2, 8'h22);
    repeat (10) @(negedge clk);
    #1 check(ras_falls == f0 + 1, "R5 one row opening for same-row writes", ras_falls - f0, 1);
    check(!dram_ras_n, "R5 page still open", dram_ras_n, 0);
    // R3 / R5 read back in the same row
    issue(0, (5 << 10) | 1, 8'h00);
    issue(0, (5 << 10) | 2, 8'h00);
    drain();

    // R6: row change forces a new opening
    f0 = ras_falls;
    issue(1, (9 << 10) | 7, 8'h77);
    issue(0, (5 << 10) | 2, 8'h00);
    drain();
    #1 check(ras_falls == f0 + 2, "R6 row miss reopens", ras_falls - f0, 2);

    // R7: idle page closes by itself
    issue(0, (9 << 10) | 7, 8'h00);
    repeat (B_PAGE + 20) @(negedge clk);
    #1 check(dram_ras_n == 1'b1, "R7 idle page closed", dram_ras_n, 1);

    // R7: a stream of same-row reads outlives one page
    f0 = ras_falls;
    for (int i = 0; i < 10; i++) issue(0, (7 << 10) | i, 8'h00);
    drain();
    #1 check(ras_falls - f0 >= 2, "R7 stream split by page limit", ras_falls - f0, 2);

    // R8: refresh grant closes and parks
    issue(1, (3 << 10) | 9, 8'h39);
    repeat (3) @(negedge clk);
    refresh_gnt = 1'b1;
    repeat (B_RMIN + B_RP + 20) @(negedge clk);
    #1 check(dram_ras_n && parked, "R8 parked under grant", {dram_ras_n, parked}, 3);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = (3 << 10) | 9;
    #1 check(!req_ready, "R8 ready low under grant", req_ready, 0);
    repeat (5) @(negedge clk);
    #1 check(dram_ras_n, "R8 request held off under grant", dram_ras_n, 1);
    req_valid = 1'b0;
    refresh_gnt = 1'b0;
    issue(0, (3 << 10) | 9, 8'h00);
    drain();

    // R2: address boundaries
    issue(1, 21'h1FFFFF, 8'hF1);
    issue(1, 21'h0003FF, 8'h3F);
    issue(1, 21'h000400, 8'h40);
    issue(0, 21'h1FFFFF, 8'h00);
    issue(0, 21'h000000, 8'h00);
    issue(0, 21'h0003FF, 8'h00);
    issue(0, 21'h000400, 8'h00);
    issue(0, 21'h155AAA, 8'h00);
    drain();

    // R11: every accepted read answered
    check(expq.size() == 0, "R11 all reads answered", expq.size(), 0);
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule